// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital side of an 8-bit successive-approximation converter. It holds a control register, a channel-select register and a read-only result register on a small synchronous register bus. It steps a trial code out to an external DAC. It reads back a single comparator bit, decides one bit per cycle from the most significant downwards, and stores the finished code. Each stored code raises a one-cycle conversion-end interrupt. While the run bit stays set, conversions follow one another without a gap.

A CPU access can land in the same cycle as a conversion finishing, and fixed rules settle the collision. A read of the result wins and sees the old value; the new code lands one cycle later. A write to the control or select register also wins; the finished code is thrown away and no interrupt follows. A status output marks the first code stored after the run bit rises, so that software can discard it. A standby input stops the sequencer at once.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control, select and result registers read as zero, and `bus_rdata`, `dac_code`, `chan_sel`, `conv_done_irq` and `first_result` are all zero.
- R2: Address 0 is the 8-bit control register and address 1 is the select register. A write to address 1 takes bits 2:0 as the channel when that value is 0 to 6; a value of 7 leaves the channel unchanged. A read returns the register value on `bus_rdata` one cycle after the read strobe, address 3 reads as zero, and `bus_rdata` holds its value between reads. `chan_sel` shows the select register.
- R3: A conversion tries bits 7 down to 0, one per cycle. `dac_code` shows the bits decided so far with the trial bit set. A trial bit is kept when `cmp_in` is 1. A ninth cycle shows the final code, which is then stored in the result register at address 2.
- R4: Each stored result raises `conv_done_irq` for exactly one cycle. While control bit 7 stays 1, the next conversion starts at once, giving one result every 9 cycles.
- R5: If a read of address 2 falls in the final cycle of a conversion, it returns the previous result. The new result is stored in the following cycle, and the interrupt comes one cycle late.
- R6: If a write to address 0 or address 1 falls in the final cycle of a conversion, the finished code is discarded and no interrupt is raised for that conversion.
- R7: Any write to address 0 or 1 with bit 7 of the resulting control value at 1 restarts the conversion from bit 7 in the next cycle. The first result then appears 9 cycles after the write.
- R8: `first_result` updates whenever a result is stored. It is 1 for the first result stored after control bit 7 goes from 0 to 1, and 0 for later results.
- R9: While `standby` is 1, the sequencer is halted: `dac_code` is 0, no result is stored and no interrupt is raised, including for a late result held back by a read collision. After release, a fresh conversion begins from bit 7, and its result is stored 10 cycles after the release.
- R10: With control bit 7 at 0, no conversion runs: `dac_code` stays 0 and no interrupt is raised.
- R11: A write to address 2 does not change the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Halts the sequencer while high |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| dac_code | output | 8 | Trial code for the DAC |
| chan_sel | output | 3 | Selected analog channel |
| conv_done_irq | output | 1 | Conversion-end interrupt pulse |
| first_result | output | 1 | The last stored result is the first after a start |

## Verification
The end of a conversion, where the result is written, can fall in the same cycle as a CPU read of the result or as a CPU write to the control or select register. The bench uses its reference model to find the final cycle of a conversion and places the bus strobe exactly there. Before that conversion it changes the analog level, so the old and new codes differ and show which one won. It then judges the `bus_rdata` value, the cycle in which the interrupt arrives or fails to arrive, and the result read back afterwards. The bench also drives standby in the middle of a conversion.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BIT  = 2'd1,
        PH_LOAD = 2'd2
    } phase_t;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CHAN = 1;
    localparam int ADDR_RSLT = 2;
endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          restart,
    input  logic          run,
    input  logic          cmp_in,
    output logic [DW-1:0] dac_code,
    output logic          load_cycle,
    output logic [DW-1:0] sar
);
    localparam int SW = $clog2(DW);

    typedef struct packed {
        phase_t        ph;
        logic [SW-1:0] idx;
        logic [DW-1:0] acc;
    } seq_t;

    seq_t s_d, s_q;
    logic [DW-1:0] trial;

    always_comb begin
        trial = s_q.acc | (DW'(1) << s_q.idx);
        s_d   = s_q;
        if (standby) begin
            s_d.ph  = PH_IDLE;
            s_d.acc = '0;
        end else if (restart) begin
            s_d.ph  = run ? PH_BIT : PH_IDLE;
            s_d.idx = SW'(DW - 1);
            s_d.acc = '0;
        end else begin
            case (s_q.ph)
                PH_IDLE: begin
                    if (run) begin
                        s_d.ph  = PH_BIT;
                        s_d.idx = SW'(DW - 1);
                        s_d.acc = '0;
                    end
                end
                PH_BIT: begin
                    if (cmp_in) s_d.acc = trial;
                    if (s_q.idx == '0) s_d.ph = PH_LOAD;
                    else               s_d.idx = s_q.idx - SW'(1);
                end
                PH_LOAD: begin
                    s_d.ph  = run ? PH_BIT : PH_IDLE;
                    s_d.idx = SW'(DW - 1);
                    s_d.acc = '0;
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.idx <= SW'(DW - 1);
            s_q.acc <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_code   = (s_q.ph == PH_BIT)  ? trial :
                        (s_q.ph == PH_LOAD) ? s_q.acc : '0;
    assign load_cycle = (s_q.ph == PH_LOAD);
    assign sar        = s_q.acc;
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 2,
    parameter int CH_N = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    standby,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DW-1:0]           bus_wdata,
    input  logic                    load_cycle,
    input  logic [DW-1:0]           sar,
    output logic [DW-1:0]           bus_rdata,
    output logic                    irq,
    output logic                    first,
    output logic                    run_next,
    output logic                    restart,
    output logic                    mode_run,
    output logic [$clog2(CH_N)-1:0] chan_sel
);
    localparam int CHW     = $clog2(CH_N);
    localparam int RUN_BIT = DW - 1;

    typedef struct packed {
        logic [DW-1:0]  mode;
        logic [CHW-1:0] sel;
        logic [DW-1:0]  res;
        logic           pend;
        logic [DW-1:0]  pend_val;
        logic [DW-1:0]  rdata;
        logic           irq;
        logic           first;
        logic           armed;
    } regs_t;

    regs_t r_d, r_q;
    logic wr_ctrl, wr_chan, rd_rslt, store_now, commit;

    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == AW'(ADDR_CTRL));
        wr_chan   = bus_wr && (bus_addr == AW'(ADDR_CHAN));
        rd_rslt   = bus_rd && (bus_addr == AW'(ADDR_RSLT));
        restart   = wr_ctrl || wr_chan;
        run_next  = wr_ctrl ? bus_wdata[RUN_BIT] : r_q.mode[RUN_BIT];
        store_now = load_cycle && !standby && !restart && !rd_rslt;
        commit    = store_now || (r_q.pend && !standby);

        r_d     = r_q;
        r_d.irq = commit;

        if (bus_rd) begin
            if (bus_addr == AW'(ADDR_CTRL))      r_d.rdata = r_q.mode;
            else if (bus_addr == AW'(ADDR_CHAN)) r_d.rdata = DW'(r_q.sel);
            else if (bus_addr == AW'(ADDR_RSLT)) r_d.rdata = r_q.res;
            else                                 r_d.rdata = '0;
        end

        r_d.pend = load_cycle && !standby && !restart && rd_rslt;
        if (r_d.pend) r_d.pend_val = sar;

        if (commit) begin
            r_d.res   = store_now ? sar : r_q.pend_val;
            r_d.first = r_q.armed;
            r_d.armed = 1'b0;
        end
        if (wr_ctrl && bus_wdata[RUN_BIT] && !r_q.mode[RUN_BIT]) r_d.armed = 1'b1;

        if (wr_ctrl) r_d.mode = bus_wdata;
        if (wr_chan && (int'(bus_wdata[CHW-1:0]) < CH_N)) r_d.sel = bus_wdata[CHW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = r_q.irq;
    assign first     = r_q.first;
    assign mode_run  = r_q.mode[RUN_BIT];
    assign chan_sel  = r_q.sel;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 2,
    parameter int CH_N = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    standby,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    cmp_in,
    output logic [DW-1:0]           dac_code,
    output logic [$clog2(CH_N)-1:0] chan_sel,
    output logic                    conv_done_irq,
    output logic                    first_result
);
    logic          load_cycle, run_next, restart, mode_run;
    logic [DW-1:0] sar;

    sar_adc_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .restart   (restart),
        .run       (run_next),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .load_cycle(load_cycle),
        .sar       (sar)
    );

    sar_adc_regs #(.DW(DW), .AW(AW), .CH_N(CH_N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .load_cycle(load_cycle),
        .sar       (sar),
        .bus_rdata (bus_rdata),
        .irq       (conv_done_irq),
        .first     (first_result),
        .run_next  (run_next),
        .restart   (restart),
        .mode_run  (mode_run),
        .chan_sel  (chan_sel)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          standby,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          irq,
    input logic          first,
    input logic [DW-1:0] dac,
    input logic          run
);
    // R4: the interrupt is a single-cycle pulse
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: standby halts the sequencer, with no result and no interrupt
    p_standby_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (dac == '0) && !irq);

    // R2: the read data holds between reads
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R10: the DAC code is idle while the run bit is clear
    p_stopped_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (dac == '0));

    // R8: the first-result flag only rises together with a stored result
    p_first_with_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first) |-> irq);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .irq      (conv_done_irq),
    .first    (first_result),
    .dac      (dac_code),
    .run      (mode_run)
);

// File: tb/sar_adc_ctrl_test.sv
`timescale 1ns/1ps
module sar_adc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic [2:0] chan_sel;
    logic       conv_done_irq;
    logic       first_result;

    int ana [0:7];
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (ana[chan_sel] >= int'(dac_code));

    sar_adc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_in(cmp_in), .dac_code(dac_code),
        .chan_sel(chan_sel), .conv_done_irq(conv_done_irq),
        .first_result(first_result)
    );

    // behavioural reference model
    int m_mode, m_sel, m_res, m_rdata, m_irq, m_first, m_armed;
    int m_pend, m_pendv, m_phase, m_bit, m_acc;

    function automatic int m_dac();
        if (m_phase == 1) return m_acc | (1 << m_bit);
        if (m_phase == 2) return m_acc;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_sel = 0; m_res = 0; m_rdata = 0; m_irq = 0;
            m_first = 0; m_armed = 0; m_pend = 0; m_pendv = 0;
            m_phase = 0; m_bit = 7; m_acc = 0;
        end else begin
            bit wm, ws, rr, load, store, npend, commit, cmpv, nrun;
            int cval, a;
            a     = int'(bus_addr);
            wm    = bus_wr && a == 0;
            ws    = bus_wr && a == 1;
            rr    = bus_rd && a == 2;
            cmpv  = ana[m_sel] >= m_dac();
            nrun  = wm ? bus_wdata[7] : m_mode[7];
            load  = (m_phase == 2);
            store = load && !standby && !(wm || ws) && !rr;
            npend = load && !standby && !(wm || ws) && rr;
            commit = store || (m_pend != 0 && !standby);
            cval  = store ? m_acc : m_pendv;
            if (bus_rd) m_rdata = (a == 0) ? m_mode : (a == 1) ? m_sel : (a == 2) ? m_res : 0;
            m_irq = commit;
            if (commit) begin m_res = cval; m_first = m_armed; m_armed = 0; end
            if (wm && bus_wdata[7] && !m_mode[7]) m_armed = 1;
            m_pend = npend;
            if (npend) m_pendv = m_acc;
            if (standby) begin
                m_phase = 0; m_acc = 0;
            end else if (wm || ws) begin
                m_phase = nrun ? 1 : 0; m_bit = 7; m_acc = 0;
            end else if (m_phase == 0) begin
                if (nrun) begin m_phase = 1; m_bit = 7; m_acc = 0; end
            end else if (m_phase == 1) begin
                if (cmpv) m_acc = m_acc | (1 << m_bit);
                if (m_bit == 0) m_phase = 2; else m_bit = m_bit - 1;
            end else begin
                m_phase = nrun ? 1 : 0; m_bit = 7; m_acc = 0;
            end
            if (wm) m_mode = int'(bus_wdata);
            if (ws && int'(bus_wdata[2:0]) < 7) m_sel = int'(bus_wdata[2:0]);
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 bus_rdata", int'(bus_rdata), m_rdata);
            chk("R2 chan_sel", int'(chan_sel), m_sel);
            chk("R3 dac_code", int'(dac_code), m_dac());
            chk("R4 conv_done_irq", int'(conv_done_irq), m_irq);
            chk("R8 first_result", int'(first_result), m_first);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        bus_addr = 2'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic wait_irq(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!conv_done_irq && cnt < 200);
    endtask

    task automatic wait_load();
        @(negedge clk);
        while (m_phase != 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int d, c;
        ana[0] = 8'hA5; ana[1] = 8'h01; ana[2] = 8'h80; ana[3] = 8'h3C;
        ana[4] = 8'h7F; ana[5] = 8'h00; ana[6] = 8'hFF; ana[7] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", int'(bus_rdata), 0);
        chk("R1 dac", int'(dac_code), 0);
        chk("R1 irq", int'(conv_done_irq), 0);
        chk("R1 first", int'(first_result), 0);
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 chan", d, 0);
        rd(2, d); chk("R1 result", d, 0);
        rd(3, d); chk("R2 addr3", d, 0);

        // R2 channel select, value 7 rejected
        wr(1, 3); rd(1, d); chk("R2 chan=3", d, 3);
        wr(1, 7); rd(1, d); chk("R2 chan 7 ignored", d, 3);

        // R3 / R8 / R4 first conversion and repeat rate
        wr(0, 8'h80);
        rd(0, d); chk("R2 ctrl", d, 8'h80);
        wait_irq(c);
        chk("R8 first flag set", int'(first_result), 1);
        rd(2, d); chk("R3 result ch3", d, 8'h3C);
        wait_irq(c);
        wait_irq(c);
        chk("R4 period", c, 9);
        chk("R8 first flag clear", int'(first_result), 0);

        // R11 result is read-only
        wr(2, 8'h55); rd(2, d); chk("R11 result unchanged", d, 8'h3C);

        // R5 read collision
        wait_irq(c);
        ana[3] = 8'h77;
        wait_load();
        bus_addr = 2'd2; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R5 read sees old", int'(bus_rdata), 8'h3C);
        chk("R5 irq deferred", int'(conv_done_irq), 0);
        @(negedge clk);
        chk("R5 irq late", int'(conv_done_irq), 1);
        rd(2, d); chk("R5 new stored", d, 8'h77);

        // R6 write collision, R7 restart timing
        wait_irq(c);
        ana[3] = 8'h11;
        wait_load();
        bus_addr = 2'd1; bus_wdata = 8'd6; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R6 irq dropped", int'(conv_done_irq), 0);
        c = 0;
        while (!conv_done_irq && c < 200) begin @(negedge clk); c++; end
        chk("R7 restart latency", c, 9);
        rd(2, d); chk("R7 result ch6", d, 8'hFF);
        wr(1, 3);
        rd(2, d); chk("R6 dropped code absent", d, 8'hFF);

        // R9 standby mid conversion
        wait_irq(c);
        @(negedge clk);
        while (!(m_phase == 1 && m_bit == 4)) @(negedge clk);
        standby = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R9 dac idle", int'(dac_code), 0);
            chk("R9 no irq", int'(conv_done_irq), 0);
        end
        standby = 1'b0;
        c = 0;
        while (!conv_done_irq && c < 200) begin @(negedge clk); c++; end
        chk("R9 resume latency", c, 10);

        // R10 stop
        wr(0, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R10 dac idle", int'(dac_code), 0);
            chk("R10 no irq", int'(conv_done_irq), 0);
        end
        rd(0, d); chk("R10 ctrl clear", d, 0);

        // R8 restart re-arms the first flag
        wr(0, 8'h81);
        wait_irq(c);
        chk("R8 first after restart", int'(first_result), 1);
        rd(2, d); chk("R3 result 0x11", d, 8'h11);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule